// File: doc/BRIEF.md
# Endpoint OUT Payload Buffer Writer

This block takes the byte stream of one received OUT data packet and places it into an endpoint buffer through a single registered memory write port. Software or a sequencer arms it for each packet. Arming gives it a buffer base address and a maximum payload length. Each received byte then goes to the next buffer address, as long as its position in the packet is below the maximum payload length. Bytes past that limit are dropped. The block keeps following the packet until the external end-of-packet strobe, so that upstream error checks can finish.

The last two bytes of every packet are its CRC. The block does not decode them. A CRC byte lands in memory only when room remains below the maximum payload length. As a result, a full-size packet stores no CRC byte, a packet one byte short of full stores only the first CRC byte, and a shorter packet stores both. At end of packet the block reports the number of data bytes. That count excludes the two CRC bytes and includes any bytes that were dropped. An abort input drops the packet in progress without reporting anything.

Top module: `out_buf_writer`

## Requirements
- R1: After a synchronous reset, wr_en and len_done are 0 and len_bytes is 0.
- R2: pkt_start latches buf_base and max_len. The first byte accepted after it is written to buf_base. Bytes presented in the pkt_start cycle are not accepted.
- R3: The byte at position i of the packet (counting from 0) is written to address buf_base + i, modulo 2^ADDR_W, with its value unchanged. wr_en rises in the cycle after rx_valid.
- R4: A byte whose position is max_len or more is never written. Reception still continues until rx_eop.
- R5: One cycle after the cycle holding rx_eop, len_done pulses for exactly one cycle. len_bytes then equals the packet's byte count (including the byte carried with rx_eop) minus two, and holds until the next report.
- R6: When the data byte count equals max_len, neither CRC byte is written.
- R7: When the data byte count equals max_len minus one, only the first CRC byte is written, at buf_base + max_len - 1.
- R8: When the data byte count is max_len minus two or less, both CRC bytes are written right after the data.
- R9: Bytes and rx_eop outside an armed packet produce no write and no report.
- R10: pkt_abort ends the packet with no report and resets the write position. Later bytes and rx_eop are ignored until the next pkt_start, which writes from buf_base again.
- R11: A packet of fewer than two bytes reports a count of 0.
- R12: With max_len of 0, no byte of the packet is written. The count is still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Arms the block for a new packet |
| buf_base | input | ADDR_W | Buffer base address, latched on pkt_start |
| max_len | input | LEN_W | Maximum payload length in bytes, latched on pkt_start |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | DATA_W | Received byte |
| rx_eop | input | 1 | End of packet; any byte in the same cycle is the last one |
| pkt_abort | input | 1 | Drops the current packet without a report |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | ADDR_W | Buffer write address |
| wr_data | output | DATA_W | Buffer write data |
| len_done | output | 1 | One-cycle pulse when the count is reported |
| len_bytes | output | LEN_W | Data byte count of the last completed packet |

## Verification
A wrong write position shows one cycle after the affected byte: the write address is off, or the write enable appears or is missing next to the limit. A position left stale by an abort or a restart shows at the first write of the next packet. A wrong byte count shows only in the cycle after end of packet. The bench therefore compares every output on every clock against a behavioural model. It also checks the captured buffer contents at the exact addresses where the CRC bytes should or should not fall.

// File: rtl/ebw_pkg.sv
package ebw_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_RECV = 1'b1} ebw_phase_e;

  // Number of bytes that remain once the two trailing check bytes are removed.
  function automatic int unsigned strip_check_bytes(input int unsigned total);
    return (total >= 2) ? total - 2 : 0;
  endfunction
endpackage

// File: rtl/ebw_pos_counter.sv
module ebw_pos_counter #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [LEN_W-1:0] pos
);
  localparam logic [LEN_W-1:0] POS_MAX = {LEN_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pos <= '0;
    end else if (step && pos != POS_MAX) begin
      pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/ebw_write_gate.sv
module ebw_write_gate #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  limit,
  input  logic [LEN_W-1:0]  pos,
  input  logic [DATA_W-1:0] din,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic in_room;
  assign in_room = (pos < limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en <= 1'b0;
    end else begin
      wr_en <= fire && in_room;
    end
  end

  // Address and data need no reset; they matter only while wr_en is high.
  always_ff @(posedge clk) begin
    if (fire) begin
      wr_addr <= base + ADDR_W'(pos);
      wr_data <= din;
    end
  end
endmodule

// File: rtl/ebw_count_report.sv
module ebw_count_report #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             step,
  input  logic [LEN_W-1:0] pos,
  output logic             done,
  output logic [LEN_W-1:0] count
);
  import ebw_pkg::*;

  localparam logic [LEN_W-1:0] POS_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] total;
  assign total = (step && pos != POS_MAX) ? pos + 1'b1 : pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      count <= '0;
    end else begin
      done <= fire;
      if (fire) begin
        count <= LEN_W'(strip_check_bytes(32'(total)));
      end
    end
  end
endmodule

// File: rtl/out_buf_writer.sv
module out_buf_writer #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_start,
  input  logic [ADDR_W-1:0] buf_base,
  input  logic [LEN_W-1:0]  max_len,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_eop,
  input  logic              pkt_abort,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              len_done,
  output logic [LEN_W-1:0]  len_bytes
);
  import ebw_pkg::*;

  ebw_phase_e        phase_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  max_q;
  logic [LEN_W-1:0]  pos;
  logic              in_recv;
  logic              active;
  logic              step;
  logic              finish;
  logic              clear;

  assign in_recv = (phase_q == PH_RECV);
  assign active  = in_recv && !pkt_abort && !pkt_start;
  assign step    = active && rx_valid;
  assign finish  = active && rx_eop;
  assign clear   = pkt_abort || pkt_start || finish;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      base_q  <= '0;
      max_q   <= '0;
    end else if (pkt_abort) begin
      phase_q <= PH_IDLE;
    end else if (pkt_start) begin
      phase_q <= PH_RECV;
      base_q  <= buf_base;
      max_q   <= max_len;
    end else if (finish) begin
      phase_q <= PH_IDLE;
    end
  end

  ebw_pos_counter #(.LEN_W(LEN_W)) pos_i (
    .clk   (clk),
    .rst   (rst),
    .clear (clear),
    .step  (step),
    .pos   (pos)
  );

  ebw_write_gate #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) gate_i (
    .clk     (clk),
    .rst     (rst),
    .fire    (step),
    .base    (base_q),
    .limit   (max_q),
    .pos     (pos),
    .din     (rx_byte),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  ebw_count_report #(.LEN_W(LEN_W)) report_i (
    .clk   (clk),
    .rst   (rst),
    .fire  (finish),
    .step  (step),
    .pos   (pos),
    .done  (len_done),
    .count (len_bytes)
  );
endmodule

// File: rtl/out_buf_writer_chk.sv
module out_buf_writer_chk #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              rx_eop,
  input logic              pkt_abort,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              len_done,
  input logic              in_recv,
  input logic [ADDR_W-1:0] base_q,
  input logic [LEN_W-1:0]  max_q
);
  logic [ADDR_W-1:0] offset;
  assign offset = wr_addr - base_q;

  // R4: every write stays below the latched payload limit
  p_below_limit_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (ADDR_W + 1)'(offset) < (ADDR_W + 1)'(max_q));

  // R3: a write always follows a presented byte
  p_write_after_byte_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(rx_valid));

  // R9: no write unless a packet was armed in the previous cycle
  p_idle_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(in_recv));

  // R5: a report only follows end of packet without abort
  p_done_after_eop_r5: assert property (@(posedge clk) disable iff (rst)
    len_done |-> ($past(rx_eop) && !$past(pkt_abort)));

  // R5: the report is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    len_done |=> !len_done);

  // R10: abort yields neither a write nor a report
  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    pkt_abort |=> (!len_done && !wr_en));

  logic unused_data;
  assign unused_data = ^wr_data;
endmodule

bind out_buf_writer out_buf_writer_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .rx_valid  (rx_valid),
  .rx_eop    (rx_eop),
  .pkt_abort (pkt_abort),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .len_done  (len_done),
  .in_recv   (in_recv),
  .base_q    (base_q),
  .max_q     (max_q)
);

// File: tb/out_buf_writer_tb_top.sv
module out_buf_writer_tb_top;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = 11;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pkt_start = 1'b0;
  logic [ADDR_W-1:0] buf_base = '0;
  logic [LEN_W-1:0]  max_len = '0;
  logic              rx_valid = 1'b0;
  logic [DATA_W-1:0] rx_byte = '0;
  logic              rx_eop = 1'b0;
  logic              pkt_abort = 1'b0;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              len_done;
  logic [LEN_W-1:0]  len_bytes;

  always #4 clk = ~clk;

  out_buf_writer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .pkt_start(pkt_start), .buf_base(buf_base),
    .max_len(max_len), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_eop(rx_eop), .pkt_abort(pkt_abort), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .len_done(len_done),
    .len_bytes(len_bytes)
  );

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";

  // Behavioural reference state
  bit m_active = 0;
  int m_base = 0, m_max = 0, m_pos = 0;
  bit e_we = 0, e_done = 0;
  int e_addr = 0, e_data = 0, e_cnt = 0;
  int mem [int];

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int mem_at(input int a);
    return mem.exists(a) ? mem[a] : -1;
  endfunction

  always @(posedge clk) begin
    e_we = 0;
    e_done = 0;
    if (rst) begin
      m_active = 0; m_pos = 0; e_cnt = 0;
    end else if (pkt_abort) begin
      m_active = 0; m_pos = 0;
    end else if (pkt_start) begin
      m_active = 1; m_base = int'(buf_base); m_max = int'(max_len); m_pos = 0;
    end else if (m_active) begin
      if (rx_valid) begin
        if (m_pos < m_max) begin
          e_we = 1;
          e_addr = (m_base + m_pos) % (1 << ADDR_W);
          e_data = int'(rx_byte);
        end
        if (m_pos < (1 << LEN_W) - 1) m_pos++;
      end
      if (rx_eop) begin
        e_done = 1;
        e_cnt = (m_pos >= 2) ? m_pos - 2 : 0;
        m_active = 0; m_pos = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(cur_req, "wr_en", int'(wr_en), int'(e_we));
      if (wr_en && e_we) begin
        check(cur_req, "wr_addr", int'(wr_addr), e_addr);
        check(cur_req, "wr_data", int'(wr_data), e_data);
      end
      check(cur_req, "len_done", int'(len_done), int'(e_done));
      check(cur_req, "len_bytes", int'(len_bytes), e_cnt);
      if (wr_en) mem[int'(wr_addr)] = int'(wr_data);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input int base, input int maxl);
    mem.delete();
    @(negedge clk);
    pkt_start = 1; buf_base = ADDR_W'(base); max_len = LEN_W'(maxl);
    @(negedge clk);
    pkt_start = 0;
  endtask

  task automatic feed(input int n, input int seed, input bit with_eop);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_byte = DATA_W'(seed + i); rx_eop = with_eop && (i == n - 1);
      @(negedge clk);
    end
    rx_valid = 0; rx_eop = 0;
  endtask

  task automatic send_pkt(input int base, input int maxl, input int n, input int seed);
    arm(base, maxl);
    feed(n, seed, 1'b1);
    idle(2);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    // R1: reset state
    check("R1", "wr_en", int'(wr_en), 0);
    check("R1", "len_done", int'(len_done), 0);
    check("R1", "len_bytes", int'(len_bytes), 0);
    rst = 0;
    idle(2);

    // R2, R8, R5: 4 data + 2 CRC, limit 8
    cur_req = "R8";
    send_pkt(12'h100, 8, 6, 8'h10);
    check("R2", "first byte at base", mem_at(12'h100), 8'h10);
    check("R8", "crc1", mem_at(12'h104), 8'h14);
    check("R8", "crc2", mem_at(12'h105), 8'h15);
    check("R8", "past end", mem_at(12'h106), -1);
    check("R5", "count", int'(len_bytes), 4);

    // R7: 7 data, limit 8
    cur_req = "R7";
    send_pkt(12'h200, 8, 9, 8'h30);
    check("R7", "crc1 kept", mem_at(12'h207), 8'h37);
    check("R7", "crc2 dropped", mem_at(12'h208), -1);
    check("R5", "count", int'(len_bytes), 7);

    // R6: 8 data, limit 8
    cur_req = "R6";
    send_pkt(12'h300, 8, 10, 8'h50);
    check("R6", "last data", mem_at(12'h307), 8'h57);
    check("R6", "no crc", mem_at(12'h308), -1);
    check("R6", "entries", mem.num(), 8);

    // R4: 8 data, limit 4
    cur_req = "R4";
    send_pkt(12'h400, 4, 10, 8'h70);
    check("R4", "last kept", mem_at(12'h403), 8'h73);
    check("R4", "entries", mem.num(), 4);
    check("R4", "count unclipped", int'(len_bytes), 8);

    // R9: traffic while idle
    cur_req = "R9";
    mem.delete();
    feed(4, 8'h80, 1'b1);
    idle(2);
    check("R9", "entries", mem.num(), 0);
    check("R9", "count held", int'(len_bytes), 8);

    // R10: abort mid-packet, then restart
    cur_req = "R10";
    arm(12'h500, 16);
    feed(3, 8'h88, 1'b0);
    pkt_abort = 1;
    @(negedge clk);
    pkt_abort = 0;
    feed(2, 8'h8C, 1'b1);
    idle(2);
    check("R10", "entries after abort", mem.num(), 3);
    check("R10", "no report", int'(len_bytes), 8);
    send_pkt(12'h500, 16, 5, 8'h90);
    check("R10", "restart at base", mem_at(12'h500), 8'h90);
    check("R10", "count", int'(len_bytes), 3);

    // R11: single-byte packet
    cur_req = "R11";
    send_pkt(12'h600, 8, 1, 8'hA0);
    check("R11", "byte", mem_at(12'h600), 8'hA0);
    check("R11", "count", int'(len_bytes), 0);

    // R12: zero limit
    cur_req = "R12";
    send_pkt(12'h700, 0, 5, 8'hB0);
    check("R12", "entries", mem.num(), 0);
    check("R12", "count", int'(len_bytes), 3);

    // R3: address wraps at the top of the space
    cur_req = "R3";
    send_pkt(12'hFFE, 8, 6, 8'hC0);
    check("R3", "top", mem_at(12'hFFF), 8'hC1);
    check("R3", "wrapped", mem_at(12'h000), 8'hC2);

    idle(2);
    finish_run();
  end
endmodule